// File: doc/BRIEF.md
# Receive Buffer with Latency Timer

This block sits between a serial receiver and the host-side packet reader. It stores incoming bytes in order and decides when they may be read. Bytes become readable only once a release (a flush) has taken place. Three things cause a flush. The first is a programmable latency timer that fires after a set number of millisecond ticks with data in the buffer. The second is an enabled match character written into the buffer. The third is a full packet's worth of bytes that have not yet been released. This lets a short message reach the host without waiting for the buffer to fill.

The reader sees show-ahead data and a count of released bytes. The timeout value is held in an 8-bit register with its own write strobe. The millisecond tick is supplied from outside.

Top module: `rx_latency_buf`

## Requirements
- R1: After reset, `fill_cnt`, `rel_cnt`, `rd_avail`, `flush_o` and `overrun_o` are 0, and the timeout register holds 16, so a lone byte is released on the 16th tick.
- R2: The buffer holds `DEPTH` (default 384) bytes and returns them in write order. `rd_data` always shows the oldest stored byte.
- R3: A read request while `rel_cnt` is 0 has no effect: no byte is removed and `fill_cnt` is unchanged.
- R4: A write on `cfg_we` loads `cfg_tmo` into the timeout register. On the N-th tick counted, where N is that value, every byte in the buffer is released (`rel_cnt` becomes `fill_cnt`).
- R5: A timeout register value of 0 acts as 1, so the first counted tick releases.
- R6: Ticks are counted only while `fill_cnt` is nonzero. Ticks that arrive while the buffer is empty do not shorten the next timeout.
- R7: The tick count restarts at zero whenever any flush occurs.
- R8: When `evt_en` is 1, an accepted byte whose 8 bits all equal `evt_char` releases every byte, including itself, on that edge. A byte differing in any bit does not release. When `evt_en` is 0, no byte releases.
- R9: When the number of stored but unreleased bytes reaches `PKT_BYTES` (default 64), all stored bytes are released.
- R10: A write while `fill_cnt` equals `DEPTH` is dropped. It sets `overrun_o`, which then stays 1 until reset.
- R11: `flush_o` is 1 for exactly the one cycle after the edge at which a flush occurred. At that moment `rel_cnt` equals `fill_cnt`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Byte write strobe from the receiver |
| wr_data | input | 8 | Byte to store |
| rd_en | input | 1 | Reader pops one released byte |
| rd_data | output | 8 | Oldest stored byte (show-ahead) |
| rd_avail | output | 1 | At least one released byte is waiting |
| rel_cnt | output | 9 | Number of released, unread bytes |
| fill_cnt | output | 9 | Number of stored bytes |
| tick_1ms | input | 1 | One-cycle millisecond tick |
| cfg_we | input | 1 | Load the timeout register |
| cfg_tmo | input | 8 | Timeout value in ticks |
| evt_en | input | 1 | Enable match-character flushing |
| evt_char | input | 8 | Match character |
| flush_o | output | 1 | One-cycle flush indication |
| overrun_o | output | 1 | Sticky dropped-write flag |

## Verification
Every result is registered once. A write, a read, a tick or a register load therefore shows on `fill_cnt`, `rel_cnt`, `flush_o` and `overrun_o` one edge after it is driven. `rd_data` reflects the new head pointer after that same edge. The bench drives inputs at the falling edge and samples at the next falling edge, so each check sees the state exactly one edge after its stimulus. Timeout checks test `rel_cnt` after every single tick, which confirms that release does not happen one tick early and does happen on the expected tick.

// File: rtl/rxlb_pkg.sv
package rxlb_pkg;
    localparam logic [7:0] TMO_RESET = 8'd16;

    // Effective tick limit: zero is promoted to one.
    function automatic logic [7:0] tmo_limit(input logic [7:0] v);
        return (v == 8'd0) ? 8'd1 : v;
    endfunction
endpackage

// File: rtl/rxlb_store.sv
module rxlb_store #(
    parameter int DEPTH = 384,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    output logic [DW-1:0] rdata
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp_d, wp_q, rp_d, rp_q;

    always_comb begin
        wp_d = wp_q;
        rp_d = rp_q;
        if (we) wp_d = (wp_q == LAST) ? '0 : wp_q + 1'b1;
        if (re) rp_d = (rp_q == LAST) ? '0 : rp_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q <= '0;
            rp_q <= '0;
        end else begin
            wp_q <= wp_d;
            rp_q <= rp_d;
        end
    end

    always_ff @(posedge clk) begin
        if (we) mem[wp_q] <= wdata;
    end

    assign rdata = mem[rp_q];
endmodule

// File: rtl/rxlb_timer.sv
module rxlb_timer (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       active,
    input  logic       restart,
    input  logic [7:0] limit_raw,
    output logic       expire
);
    import rxlb_pkg::*;

    logic [7:0] cnt_d, cnt_q;
    logic [7:0] lim;

    always_comb begin
        lim    = tmo_limit(limit_raw);
        expire = tick && active && (({1'b0, cnt_q} + 9'd1) >= {1'b0, lim});
        cnt_d  = cnt_q;
        if (restart || !active) cnt_d = '0;
        else if (tick)          cnt_d = cnt_q + 8'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rx_latency_buf.sv
module rx_latency_buf #(
    parameter int DEPTH     = 384,
    parameter int PKT_BYTES = 64,
    parameter int CW        = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic          rd_en,
    output logic [7:0]    rd_data,
    output logic          rd_avail,
    output logic [CW-1:0] rel_cnt,
    output logic [CW-1:0] fill_cnt,
    input  logic          tick_1ms,
    input  logic          cfg_we,
    input  logic [7:0]    cfg_tmo,
    input  logic          evt_en,
    input  logic [7:0]    evt_char,
    output logic          flush_o,
    output logic          overrun_o
);
    import rxlb_pkg::*;

    localparam logic [CW-1:0] FULL = CW'(DEPTH);
    localparam logic [CW-1:0] PKT  = CW'(PKT_BYTES);

    typedef struct packed {
        logic [CW-1:0] count;
        logic [CW-1:0] rel;
        logic [7:0]    tmo;
        logic          flush;
        logic          ovr;
    } state_t;

    state_t st_d, st_q;

    logic          wr_ok, rd_ok, evt_hit, pkt_hit, tmo_hit;
    logic [CW-1:0] rel_left, unrel;

    rxlb_store #(.DEPTH(DEPTH), .DW(8)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_ok),
        .wdata (wr_data),
        .re    (rd_ok),
        .rdata (rd_data)
    );

    rxlb_timer u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_1ms),
        .active    (st_q.count != '0),
        .restart   (st_d.flush),
        .limit_raw (st_q.tmo),
        .expire    (tmo_hit)
    );

    always_comb begin
        st_d     = st_q;
        wr_ok    = wr_en && (st_q.count != FULL);
        rd_ok    = rd_en && (st_q.rel != '0);
        evt_hit  = wr_ok && evt_en && (wr_data == evt_char);

        st_d.count = st_q.count + CW'(wr_ok) - CW'(rd_ok);
        rel_left   = st_q.rel - CW'(rd_ok);
        unrel      = st_d.count - rel_left;
        pkt_hit    = unrel >= PKT;

        st_d.flush = evt_hit || pkt_hit || tmo_hit;
        st_d.rel   = st_d.flush ? st_d.count : rel_left;

        if (wr_en && !wr_ok) st_d.ovr = 1'b1;
        if (cfg_we)          st_d.tmo = cfg_tmo;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.count <= '0;
            st_q.rel   <= '0;
            st_q.tmo   <= TMO_RESET;
            st_q.flush <= 1'b0;
            st_q.ovr   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_avail  = st_q.rel != '0;
    assign rel_cnt   = st_q.rel;
    assign fill_cnt  = st_q.count;
    assign flush_o   = st_q.flush;
    assign overrun_o = st_q.ovr;
endmodule

// File: rtl/rxlb_checker.sv
module rxlb_checker #(
    parameter int DEPTH = 384,
    parameter int CW    = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [7:0]    wr_data,
    input logic          rd_en,
    input logic          evt_en,
    input logic [7:0]    evt_char,
    input logic [CW-1:0] rel_cnt,
    input logic [CW-1:0] fill_cnt,
    input logic          flush_o,
    input logic          overrun_o
);
    p_rel_within_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rel_cnt <= fill_cnt);

    p_idle_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rel_cnt == '0 && !wr_en) |=> $stable(fill_cnt));

    p_evt_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && evt_en && wr_data == evt_char && fill_cnt != CW'(DEPTH))
        |=> (flush_o && rel_cnt == fill_cnt));

    p_drop_when_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && fill_cnt == CW'(DEPTH)) |=> (fill_cnt == CW'(DEPTH) && overrun_o));

    p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |=> overrun_o);

    p_flush_releases_all_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> rel_cnt == fill_cnt);
endmodule

bind rx_latency_buf rxlb_checker #(.DEPTH(DEPTH), .CW(CW)) u_rxlb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .evt_en    (evt_en),
    .evt_char  (evt_char),
    .rel_cnt   (rel_cnt),
    .fill_cnt  (fill_cnt),
    .flush_o   (flush_o),
    .overrun_o (overrun_o)
);

// File: tb/rx_latency_buf_bench.sv
module rx_latency_buf_bench;
    localparam int DEPTH = 384;
    localparam int CW    = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0, tick_1ms = 1'b0, cfg_we = 1'b0, evt_en = 1'b0;
    logic [7:0] wr_data = '0, cfg_tmo = '0, evt_char = '0;
    logic [7:0] rd_data;
    logic rd_avail, flush_o, overrun_o;
    logic [CW-1:0] rel_cnt, fill_cnt;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    rx_latency_buf #(.DEPTH(DEPTH), .PKT_BYTES(64)) u_rx_latency_buf (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .rd_avail(rd_avail),
        .rel_cnt(rel_cnt), .fill_cnt(fill_cnt), .tick_1ms(tick_1ms),
        .cfg_we(cfg_we), .cfg_tmo(cfg_tmo), .evt_en(evt_en),
        .evt_char(evt_char), .flush_o(flush_o), .overrun_o(overrun_o)
    );

    // {programmed timeout, ticks until release}
    localparam logic [15:0] TV [5] = '{
        {8'd3, 8'd3}, {8'd0, 8'd1}, {8'd1, 8'd1}, {8'd7, 8'd7}, {8'd255, 8'd255}
    };

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick();
        tick_1ms = 1'b1;
        @(negedge clk);
        tick_1ms = 1'b0;
    endtask

    task automatic pop(output logic [7:0] d);
        d = rd_data;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic set_tmo(input logic [7:0] v);
        cfg_we = 1'b1; cfg_tmo = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(fill_cnt == 0 && rel_cnt == 0 && !rd_avail, "R1 counts", fill_cnt, 0);
        chk(!flush_o && !overrun_o, "R1 flags", {flush_o, overrun_o}, 0);

        // R1: default timeout of 16 ticks
        put(8'h5A);
        for (int k = 1; k < 16; k++) begin
            tick();
            chk(rel_cnt == 0, "R1 early release", rel_cnt, 0);
        end
        tick();
        chk(rel_cnt == 1 && flush_o, "R1 release on 16th tick", rel_cnt, 1);
        @(negedge clk);
        chk(!flush_o, "R11 flush single cycle", flush_o, 0);
        pop(d);
        chk(d == 8'h5A && fill_cnt == 0, "R2 data", d, 8'h5A);

        // R4 R5: table of timeout settings
        foreach (TV[i]) begin
            set_tmo(TV[i][15:8]);
            put(8'h40 + 8'(i));
            for (int k = 1; k < int'(TV[i][7:0]); k++) begin
                tick();
                chk(rel_cnt == 0, "R4 early release", rel_cnt, 0);
            end
            tick();
            chk(rel_cnt == 1 && fill_cnt == 1, "R4/R5 release", rel_cnt, 1);
            chk(flush_o, "R11 flush after timeout", flush_o, 1);
            pop(d);
            chk(d == 8'h40 + 8'(i), "R4 data", d, 8'h40 + i);
        end

        // R6: ticks with empty buffer are not counted; R3 idle read
        set_tmo(8'd4);
        repeat (10) tick();
        put(8'h21);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk(fill_cnt == 1 && rel_cnt == 0, "R3 read before release", fill_cnt, 1);
        repeat (3) tick();
        chk(rel_cnt == 0, "R6 empty ticks counted", rel_cnt, 0);
        tick();
        chk(rel_cnt == 1, "R6 release after 4 ticks", rel_cnt, 1);
        pop(d);

        // R8: match character
        evt_en = 1'b1; evt_char = 8'hA5;
        put(8'h11);
        put(8'h25);
        chk(rel_cnt == 0 && !flush_o, "R8 one-bit mismatch", rel_cnt, 0);
        put(8'hA5);
        chk(rel_cnt == 3 && flush_o, "R8 match flush", rel_cnt, 3);
        pop(d); chk(d == 8'h11, "R2 order 1", d, 8'h11);
        pop(d); chk(d == 8'h25, "R2 order 2", d, 8'h25);
        pop(d); chk(d == 8'hA5, "R2 order 3", d, 8'hA5);
        evt_en = 1'b0;
        put(8'hA5);
        chk(rel_cnt == 0 && !flush_o, "R8 disabled", rel_cnt, 0);

        // R7: any flush restarts the tick count
        repeat (3) tick();
        evt_en = 1'b1;
        put(8'hA5);
        evt_en = 1'b0;
        chk(rel_cnt == 2, "R7 match flush", rel_cnt, 2);
        put(8'h33);
        repeat (3) tick();
        chk(rel_cnt == 2, "R7 count not restarted", rel_cnt, 2);
        tick();
        chk(rel_cnt == 3, "R7 release after restart", rel_cnt, 3);
        repeat (3) pop(d);
        chk(fill_cnt == 0, "R2 drained", fill_cnt, 0);

        // R9 R10 R2: packet release, fill to capacity, overrun
        for (int n = 0; n < 63; n++) put(8'(n));
        chk(rel_cnt == 0, "R9 below packet", rel_cnt, 0);
        put(8'd63);
        chk(rel_cnt == 64 && flush_o, "R9 packet release", rel_cnt, 64);
        for (int n = 64; n < DEPTH; n++) put(8'(n));
        chk(fill_cnt == DEPTH && !overrun_o, "R2 capacity", fill_cnt, DEPTH);
        put(8'hEE);
        chk(fill_cnt == DEPTH && overrun_o, "R10 drop and flag", fill_cnt, DEPTH);
        for (int n = 0; n < DEPTH; n++) begin
            pop(d);
            if (d != 8'(n)) chk(1'b0, "R2 order", d, n & 255);
        end
        chk(fill_cnt == 0, "R2 drained after full", fill_cnt, 0);
        chk(overrun_o, "R10 sticky", overrun_o, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule